// File: doc/BRIEF.md
# Memory controller init sequencer

This block runs once after reset and drives a series of register writes into a DDR memory controller until the controller is ready for use. It speaks a plain write-only handshake bus: it presents an address and a data word with `wr_valid` and moves on only when the controller accepts them with `wr_ready`. It does not model the memory device or the controller datapath. It only decides which registers get which words, and in what order.

Two strap pins select the script. `strap_ddr2` picks the DDR2 bring-up (mode registers, extended mode registers, DLL reset, refresh commands, drive calibration) or the shorter DDR1 bring-up. `strap_ref40` picks the refresh interval that suits a 40 MHz reference clock over a 25 MHz one. Both straps are captured once, when the script starts. When the last write is accepted, `init_done` rises and stays high until the next reset.

The controller registers sit on word offsets: timing A 0x00, timing B 0x04, command 0x08, mode 0x0C, extended mode 0x10, refresh 0x14, strobe tap 0 0x18, strobe tap 1 0x1C, read cycle 0x20, bus timeout 0x24, extended mode 2 0x28, extended mode 3 0x2C, DDR2 config 0x30. In a word written to the command register, each bit starts one action: bit 0 loads the mode register, bit 1 loads the extended mode register, bit 2 runs an auto-refresh, bit 3 precharges all banks, bit 4 loads extended mode 2 and bit 5 loads extended mode 3.

Top module: `memctl_init_seq`

## Requirements
- R1: While `rst_n` is low, `wr_valid` and `init_done` are low. The first write request is shown after the first rising edge at which `rst_n` is high.
- R2: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R3: Both scripts begin with 0x7FBC8CD0 to timing A (0x00), then 0x9DD0E6A8 to timing B (0x04), then 0x000FFFFF to bus timeout (0x24).
- R4: With `strap_ddr2`=1, the script continues with these (offset, data) pairs: (0x30,DDR2 config), (0x08,0x08), (0x28,0), (0x08,0x10), (0x2C,0), (0x08,0x20), (0x10,0), (0x08,0x02), (0x0C,0x100), (0x08,0x01), (0x08,0x08), (0x08,0x04), (0x08,0x04), (0x0C,0xA33), (0x08,0x01), (0x10,0x382), (0x08,0x02), (0x10,0x402), (0x08,0x02).
- R5: The DDR2 config word is 0x00000A59: write latency 2 in bits 13:10, on-die termination enable in bit 9, four-activate window 22 in bits 7:2, and DDR2 enable in bit 0.
- R6: With `strap_ddr2`=0, the script continues with (0x08,0x08), (0x0C,0x133), (0x08,0x01), (0x10,0x02), (0x08,0x02), (0x08,0x08), (0x0C,0x33), (0x08,0x01).
- R7: Next comes the refresh word to 0x14: enable bit 14 ORed with a 10-bit interval of 624, which is 0x4270, when `strap_ref40`=1, and of 390, which is 0x4186, when it is 0.
- R8: Both scripts end with 0x08 to tap 0 (0x18), then 0x09 to tap 1 (0x1C), then 0xFF to read cycle (0x20).
- R9: The straps are captured on the edge that starts the script. Later changes on the strap pins do not alter any write of that run.
- R10: `init_done` rises on the edge that completes the final handshake. After that it stays high and `wr_valid` stays low until reset.
- R11: A DDR2 run makes exactly 26 accepted writes and a DDR1 run makes exactly 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_ddr2 | input | 1 | 1 selects the DDR2 script, 0 selects the DDR1 script |
| strap_ref40 | input | 1 | 1 selects refresh for a 40 MHz reference clock, 0 for 25 MHz |
| wr_addr | output | ADDR_W | Register offset of the current write |
| wr_data | output | DATA_W | Data of the current write |
| wr_valid | output | 1 | A write request is being presented |
| wr_ready | input | 1 | The controller accepts the write on this edge |
| init_done | output | 1 | The script is complete (sticky until reset) |

## Verification
The first request is due one rising edge after reset release. Each later request is due on the edge after the handshake before it, and `init_done` is due on the edge of the final handshake, with no gap cycle. The bench changes `wr_ready` and samples every output on falling edges. It counts a handshake at a falling edge where it has just set `wr_ready` high while `wr_valid` is high, and compares that write with the next entry of a script it builds from the requirements. It checks that `init_done` is high at exactly the falling edge after the last handshake, so each result is read half a cycle after the edge that produces it. The checks run over every strap combination, with both a bus that is always ready and a bus that stalls, and also with the straps flipped partway through a run.

// File: rtl/memctl_init_pkg.sv
package memctl_init_pkg;

    typedef enum logic [3:0] {
        RG_TIMING_A = 4'd0,
        RG_TIMING_B = 4'd1,
        RG_CMD      = 4'd2,
        RG_MODE     = 4'd3,
        RG_EXT      = 4'd4,
        RG_REFRESH  = 4'd5,
        RG_TAP0     = 4'd6,
        RG_TAP1     = 4'd7,
        RG_RDCYC    = 4'd8,
        RG_TIMEOUT  = 4'd9,
        RG_EXT2     = 4'd10,
        RG_EXT3     = 4'd11,
        RG_DDR2CFG  = 4'd12
    } reg_id_e;

    typedef enum logic [1:0] {
        S_START = 2'd0,
        S_ISSUE = 2'd1,
        S_DONE  = 2'd2
    } seq_state_e;

    localparam int DDR2_LEN = 26;
    localparam int DDR1_LEN = 15;
    localparam int TAIL_LEN = 4;
    localparam int HEAD_LEN = 3;
    localparam int STEP_W   = $clog2(DDR2_LEN);

    // command register action bits
    localparam logic [31:0] CMD_MODE_LOAD = 32'h01;
    localparam logic [31:0] CMD_EXT_LOAD  = 32'h02;
    localparam logic [31:0] CMD_AUTO_REF  = 32'h04;
    localparam logic [31:0] CMD_PRECHARGE = 32'h08;
    localparam logic [31:0] CMD_EXT2_LOAD = 32'h10;
    localparam logic [31:0] CMD_EXT3_LOAD = 32'h20;

    // timing word A: RAS 16, RCD 6, RP 6, RRD 4, RFC 30, MRD 15, CAS 7, open page
    localparam logic [31:0] TIMING_A_WORD =
        (32'd16) | (32'd6 << 5) | (32'd6 << 9) | (32'd4 << 13) |
        (32'd30 << 17) | (32'd15 << 23) | (32'd7 << 27) | (32'd1 << 30);

    // timing word B: burst 8, output enable, CKE, WR 6, RTW 14, RTP 8, WTR 14, gate 7, half width
    localparam logic [31:0] TIMING_B_WORD =
        (32'd8) | (32'd1 << 5) | (32'd1 << 7) | (32'd6 << 8) |
        (32'd14 << 12) | (32'd8 << 17) | (32'd14 << 21) | (32'd7 << 26) |
        (32'd1 << 31);

    localparam logic [31:0] DDR2_CFG_WORD =
        (32'd2 << 10) | (32'd1 << 9) | (32'd22 << 2) | 32'd1;

    localparam logic [31:0] TIMEOUT_WORD = 32'h000F_FFFF;
    localparam logic [31:0] REFRESH_EN   = 32'd1 << 14;

    function automatic logic [31:0] refresh_word(input logic ref40);
        logic [9:0] interval;
        interval = ref40 ? 10'd624 : 10'd390;
        return REFRESH_EN | {22'd0, interval};
    endfunction

    function automatic logic [7:0] reg_offset(input reg_id_e r);
        return {2'b00, r, 2'b00};
    endfunction

endpackage

// File: rtl/memctl_init_strap.sv
module memctl_init_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic ddr2_pin,
    input  logic ref40_pin,
    output logic ddr2_q,
    output logic ref40_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ddr2_q  <= 1'b0;
            ref40_q <= 1'b0;
        end else if (capture) begin
            ddr2_q  <= ddr2_pin;
            ref40_q <= ref40_pin;
        end
    end
endmodule

// File: rtl/memctl_init_rom.sv
module memctl_init_rom
    import memctl_init_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SW     = STEP_W
) (
    input  logic [SW-1:0]     step,
    input  logic              is_ddr2,
    input  logic              ref40,
    output reg_id_e           reg_id,
    output logic [DATA_W-1:0] data,
    output logic              last
);
    localparam int BODY2_END = DDR2_LEN - TAIL_LEN;
    localparam int BODY1_END = DDR1_LEN - TAIL_LEN;

    logic [31:0] word;
    int          idx;
    int          tail_idx;

    assign idx      = int'(step);
    assign tail_idx = idx - (is_ddr2 ? BODY2_END : BODY1_END);
    assign data     = DATA_W'(word);

    always_comb begin
        reg_id = RG_CMD;
        word   = 32'd0;
        last   = 1'b0;
        if (idx < HEAD_LEN) begin
            case (idx)
                0:       begin reg_id = RG_TIMING_A; word = TIMING_A_WORD; end
                1:       begin reg_id = RG_TIMING_B; word = TIMING_B_WORD; end
                default: begin reg_id = RG_TIMEOUT;  word = TIMEOUT_WORD;  end
            endcase
        end else if (is_ddr2 && idx < BODY2_END) begin
            case (idx)
                3:       begin reg_id = RG_DDR2CFG; word = DDR2_CFG_WORD; end
                4:       begin reg_id = RG_CMD;  word = CMD_PRECHARGE; end
                5:       begin reg_id = RG_EXT2; word = 32'd0;         end
                6:       begin reg_id = RG_CMD;  word = CMD_EXT2_LOAD; end
                7:       begin reg_id = RG_EXT3; word = 32'd0;         end
                8:       begin reg_id = RG_CMD;  word = CMD_EXT3_LOAD; end
                9:       begin reg_id = RG_EXT;  word = 32'd0;         end
                10:      begin reg_id = RG_CMD;  word = CMD_EXT_LOAD;  end
                11:      begin reg_id = RG_MODE; word = 32'h100;       end
                12:      begin reg_id = RG_CMD;  word = CMD_MODE_LOAD; end
                13:      begin reg_id = RG_CMD;  word = CMD_PRECHARGE; end
                14:      begin reg_id = RG_CMD;  word = CMD_AUTO_REF;  end
                15:      begin reg_id = RG_CMD;  word = CMD_AUTO_REF;  end
                16:      begin reg_id = RG_MODE; word = 32'hA33;       end
                17:      begin reg_id = RG_CMD;  word = CMD_MODE_LOAD; end
                18:      begin reg_id = RG_EXT;  word = 32'h382;       end
                19:      begin reg_id = RG_CMD;  word = CMD_EXT_LOAD;  end
                20:      begin reg_id = RG_EXT;  word = 32'h402;       end
                default: begin reg_id = RG_CMD;  word = CMD_EXT_LOAD;  end
            endcase
        end else if (!is_ddr2 && idx < BODY1_END) begin
            case (idx)
                3:       begin reg_id = RG_CMD;  word = CMD_PRECHARGE; end
                4:       begin reg_id = RG_MODE; word = 32'h133;       end
                5:       begin reg_id = RG_CMD;  word = CMD_MODE_LOAD; end
                6:       begin reg_id = RG_EXT;  word = 32'h02;        end
                7:       begin reg_id = RG_CMD;  word = CMD_EXT_LOAD;  end
                8:       begin reg_id = RG_CMD;  word = CMD_PRECHARGE; end
                9:       begin reg_id = RG_MODE; word = 32'h33;        end
                default: begin reg_id = RG_CMD;  word = CMD_MODE_LOAD; end
            endcase
        end else begin
            case (tail_idx)
                0:       begin reg_id = RG_REFRESH; word = refresh_word(ref40); end
                1:       begin reg_id = RG_TAP0;    word = 32'h08; end
                2:       begin reg_id = RG_TAP1;    word = 32'h09; end
                default: begin reg_id = RG_RDCYC;   word = 32'hFF; last = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/memctl_init_seq.sv
module memctl_init_seq
    import memctl_init_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_ddr2,
    input  logic              strap_ref40,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic              init_done
);
    localparam int SW = STEP_W;

    seq_state_e        state;
    logic [SW-1:0]     step;
    logic              ddr2_q;
    logic              ref40_q;
    reg_id_e           cur_reg;
    logic [DATA_W-1:0] cur_data;
    logic              cur_last;

    memctl_init_strap u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (state == S_START),
        .ddr2_pin  (strap_ddr2),
        .ref40_pin (strap_ref40),
        .ddr2_q    (ddr2_q),
        .ref40_q   (ref40_q)
    );

    memctl_init_rom #(.DATA_W(DATA_W), .SW(SW)) u_rom (
        .step    (step),
        .is_ddr2 (ddr2_q),
        .ref40   (ref40_q),
        .reg_id  (cur_reg),
        .data    (cur_data),
        .last    (cur_last)
    );

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_START;
            step  <= '0;
        end else begin
            unique case (state)
                S_START: begin
                    state <= S_ISSUE;
                    step  <= '0;
                end
                S_ISSUE: begin
                    if (wr_ready) begin
                        if (cur_last) state <= S_DONE;
                        else          step  <= step + 1'b1;
                    end
                end
                S_DONE:  state <= S_DONE;
                default: state <= S_START;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        wr_valid  = 1'b0;
        init_done = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        unique case (state)
            S_ISSUE: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(reg_offset(cur_reg));
                wr_data  = cur_data;
            end
            S_DONE:  init_done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/memctl_init_chk.sv
module memctl_init_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              init_done
);
    logic [7:0] hs_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hs_cnt <= 8'd0;
        else if (wr_valid && wr_ready) hs_cnt <= hs_cnt + 8'd1;
    end

    assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !wr_valid);

    assert_done_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(wr_valid && wr_ready));

    assert_write_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (hs_cnt == 8'd15 || hs_cnt == 8'd26));

    assert_refresh_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_W'(8'h14)) |->
        (wr_data == DATA_W'(32'h4270) || wr_data == DATA_W'(32'h4186)));
endmodule

bind memctl_init_seq memctl_init_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .init_done (init_done)
);

// File: tb/memctl_init_seq_bench.sv
module memctl_init_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_ddr2 = 1'b0;
    logic        strap_ref40 = 1'b0;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic        init_done;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0]  exp_a [32];
    logic [31:0] exp_d [32];
    string       exp_r [32];
    int          exp_n;

    always #10 clk = ~clk;

    memctl_init_seq u_memctl_init_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_ddr2  (strap_ddr2),
        .strap_ref40 (strap_ref40),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .init_done   (init_done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [31:0] d, input string r);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_r[exp_n] = r;
        exp_n++;
    endtask

    task automatic build(input bit ddr2, input bit ref40);
        exp_n = 0;
        push(8'h00, 32'h7FBC8CD0, "R3");
        push(8'h04, 32'h9DD0E6A8, "R3");
        push(8'h24, 32'h000FFFFF, "R3");
        if (ddr2) begin
            push(8'h30, 32'h00000A59, "R5");
            push(8'h08, 32'h08, "R4"); push(8'h28, 32'h0, "R4");
            push(8'h08, 32'h10, "R4"); push(8'h2C, 32'h0, "R4");
            push(8'h08, 32'h20, "R4"); push(8'h10, 32'h0, "R4");
            push(8'h08, 32'h02, "R4"); push(8'h0C, 32'h100, "R4");
            push(8'h08, 32'h01, "R4"); push(8'h08, 32'h08, "R4");
            push(8'h08, 32'h04, "R4"); push(8'h08, 32'h04, "R4");
            push(8'h0C, 32'hA33, "R4"); push(8'h08, 32'h01, "R4");
            push(8'h10, 32'h382, "R4"); push(8'h08, 32'h02, "R4");
            push(8'h10, 32'h402, "R4"); push(8'h08, 32'h02, "R4");
        end else begin
            push(8'h08, 32'h08, "R6"); push(8'h0C, 32'h133, "R6");
            push(8'h08, 32'h01, "R6"); push(8'h10, 32'h02, "R6");
            push(8'h08, 32'h02, "R6"); push(8'h08, 32'h08, "R6");
            push(8'h0C, 32'h33, "R6"); push(8'h08, 32'h01, "R6");
        end
        push(8'h14, (32'd1 << 14) | (ref40 ? 32'd624 : 32'd390), "R7");
        push(8'h18, 32'h08, "R8");
        push(8'h1C, 32'h09, "R8");
        push(8'h20, 32'hFF, "R8");
    endtask

    task automatic run_case(input bit ddr2, input bit ref40, input bit stall, input bit flip);
        int idx = 0;
        int cyc = 0;
        int last_hs = -10;
        bit prev_stall = 0;
        logic [7:0]  prev_a = 8'h0;
        logic [31:0] prev_d = 32'h0;
        build(ddr2, ref40);
        @(negedge clk);
        rst_n = 1'b0;
        wr_ready = 1'b0;
        strap_ddr2 = ddr2;
        strap_ref40 = ref40;
        repeat (3) @(negedge clk);
        check(!wr_valid, "R1 valid in reset", 32'(wr_valid), 32'd0);
        check(!init_done, "R1 done in reset", 32'(init_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_valid && !init_done, "R1 first request", 32'(wr_valid), 32'd1);
        while (!init_done && cyc < 200) begin
            if (flip && idx == 1) begin
                strap_ddr2 = !ddr2;
                strap_ref40 = !ref40;
            end
            wr_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (wr_valid) begin
                if (prev_stall) begin
                    check(wr_addr == prev_a, "R2 addr hold", 32'(wr_addr), 32'(prev_a));
                    check(wr_data == prev_d, "R2 data hold", wr_data, prev_d);
                end
                if (wr_ready) begin
                    if (idx < exp_n) begin
                        check(wr_addr == exp_a[idx], flip ? "R9 addr" : exp_r[idx], 32'(wr_addr), 32'(exp_a[idx]));
                        check(wr_data == exp_d[idx], flip ? "R9 data" : exp_r[idx], wr_data, exp_d[idx]);
                    end else begin
                        check(1'b0, "R11 extra write", 32'(idx), 32'(exp_n));
                    end
                    idx++;
                    last_hs = cyc;
                    prev_stall = 0;
                end else begin
                    prev_stall = 1;
                    prev_a = wr_addr;
                    prev_d = wr_data;
                end
            end else begin
                check(1'b0, "R1 request dropped", 32'(wr_valid), 32'd1);
            end
            @(negedge clk);
            cyc++;
        end
        wr_ready = 1'b0;
        check(init_done, "R10 done raised", 32'(init_done), 32'd1);
        check(idx == exp_n, "R11 write count", 32'(idx), 32'(exp_n));
        check(cyc == last_hs + 1, "R10 done timing", 32'(cyc), 32'(last_hs + 1));
        for (int k = 0; k < 8; k++) begin
            wr_ready = k[0];
            @(negedge clk);
            check(init_done && !wr_valid, "R10 sticky done", {30'd0, init_done, wr_valid}, 32'd2);
        end
        wr_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int d = 0; d < 2; d++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 2; s++)
                    run_case(d[0], r[0], s[0], 1'b0);
        run_case(1'b1, 1'b0, 1'b1, 1'b1);
        run_case(1'b0, 1'b1, 1'b0, 1'b1);
        finish_run();
    end
endmodule